// File: doc/BRIEF.md
# Lockable PWM Channel

This block is a single pulse-width modulation channel driven by a small register port. A write strobe, a two-bit register select and a 32-bit data word load three shadow registers: a control word, a period and a duty count. Reads return the shadow contents one clock after the select is presented. A fixed prescaler produces one tick every `PRESCALE` clocks. A counter advances on those ticks and wraps once per period.

The waveform is never generated from the shadow registers directly. An active copy of period, duty and output levels is loaded from the shadow copy only at a period boundary, and all fields load together in that one cycle. A lock bit in the control word blocks this load completely. Software can therefore set the lock, rewrite period and duty, then clear the lock. The new configuration then starts cleanly at the start of the next period.

The output follows the active configuration only when a set of control bits is in its run state. In every other case it holds the programmed idle level. The active-phase level and the idle level are programmed independently, which gives normal polarity, inverted polarity, or a constant level.

Top module: `pwm_lock_chan`

## Requirements
- R1: After a synchronous reset, `pwm_out` is 0 and reads of the control, period and duty registers return 0.
- R2: Register select 0 is the control word, 1 is the period and 2 is the duty. `rdata` shows the selected shadow register one clock after `addr` is applied. Select 3 reads as 0, and writes to select 3 are ignored.
- R3: The waveform runs only when control bit 0 (enable) and bit 1 (continuous) are both 1 and bit 5 (alignment) and bit 8 (low power) are both 0. In any other case `pwm_out` holds the idle level.
- R4: While running, `pwm_out` spends DUTY ticks at the active level and then PERIOD−DUTY ticks at the idle level. One tick is `PRESCALE` clocks (default 2).
- R5: Control bit 3 sets the active-phase level and control bit 4 sets the idle level. Normal polarity is 0x0B; inverted polarity is 0x13.
- R6: When DUTY is greater than or equal to a nonzero PERIOD, `pwm_out` stays at the active level for the whole period.
- R7: A PERIOD of 0 holds `pwm_out` at the idle level.
- R8: While control bit 6 (lock) is 1, writes to period and duty change only the shadow copies and do not change the running waveform.
- R9: Period, duty and output levels move from the shadow copy to the active copy together, and only at a period boundary. A write made part-way through a period does not shorten or stretch that period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the selected register |
| addr | input | 2 | Register select: 0 control, 1 period, 2 duty |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read-back of the selected shadow register |
| pwm_out | output | 1 | Registered modulated output |

## Verification
The assertions assume that reset is applied only from time zero and is never raised again mid-run. The lock-hold and idle-level properties rely on the cycle before being out of reset. The tick-spacing property assumes `PRESCALE` is at least 2, which is the default used here. The bench resets only at the start, keeps `addr` to the three defined selects apart from one deliberate read of select 3, and loads each new configuration under the lock. This means no period ever runs on a half-written period and duty pair, and each measured period is a fully committed one.

// File: rtl/pwm_lock_pkg.sv
package pwm_lock_pkg;

  // control word bit positions (decoded by software, so positions are fixed)
  localparam int CB_ENABLE  = 0;
  localparam int CB_CONT    = 1;
  localparam int CB_ACT_HI  = 3;
  localparam int CB_IDLE_HI = 4;
  localparam int CB_ALIGN   = 5;
  localparam int CB_LOCK    = 6;
  localparam int CB_LOWPWR  = 8;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_DUTY   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // decoded view of the shadow control word
  typedef struct packed {
    logic enable;
    logic cont;
    logic act_hi;
    logic idle_hi;
    logic align;
    logic lock;
    logic lowpwr;
  } ctrl_view_t;

  // fields the waveform generator actually uses
  typedef struct packed {
    logic run;
    logic act_hi;
    logic idle_hi;
  } wave_mode_t;

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  generate
    if (DIV > 1) begin : g_div
      logic [PW-1:0] pcnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          pcnt <= '0;
        end else if (pcnt == LAST) begin
          pcnt <= '0;
        end else begin
          pcnt <= pcnt + PW'(1);
        end
      end
      assign tick = (pcnt == LAST);
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_lock_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output ctrl_view_t   sh_ctrl,
  output logic [W-1:0] sh_period,
  output logic [W-1:0] sh_duty
);
  logic [W-1:0] ctrl_q;
  logic [W-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      sh_period <= '0;
      sh_duty   <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(addr))
        SEL_CTRL:   ctrl_q    <= wdata;
        SEL_PERIOD: sh_period <= wdata;
        SEL_DUTY:   sh_duty   <= wdata;
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (reg_sel_e'(addr))
      SEL_CTRL:   rd_next = ctrl_q;
      SEL_PERIOD: rd_next = sh_period;
      SEL_DUTY:   rd_next = sh_duty;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  assign sh_ctrl.enable  = ctrl_q[CB_ENABLE];
  assign sh_ctrl.cont    = ctrl_q[CB_CONT];
  assign sh_ctrl.act_hi  = ctrl_q[CB_ACT_HI];
  assign sh_ctrl.idle_hi = ctrl_q[CB_IDLE_HI];
  assign sh_ctrl.align   = ctrl_q[CB_ALIGN];
  assign sh_ctrl.lock    = ctrl_q[CB_LOCK];
  assign sh_ctrl.lowpwr  = ctrl_q[CB_LOWPWR];
endmodule

// File: rtl/pwm_commit.sv
module pwm_commit
  import pwm_lock_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         boundary,
  input  ctrl_view_t   sh_ctrl,
  input  logic [W-1:0] sh_period,
  input  logic [W-1:0] sh_duty,
  output logic         commit,
  output logic [W-1:0] act_period,
  output logic [W-1:0] act_duty,
  output wave_mode_t   act_mode
);
  wave_mode_t next_mode;

  assign next_mode.run     = sh_ctrl.enable & sh_ctrl.cont &
                             ~sh_ctrl.align & ~sh_ctrl.lowpwr;
  assign next_mode.act_hi  = sh_ctrl.act_hi;
  assign next_mode.idle_hi = sh_ctrl.idle_hi;

  assign commit = tick & boundary & ~sh_ctrl.lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_period <= '0;
      act_duty   <= '0;
      act_mode   <= '0;
    end else if (commit) begin
      act_period <= sh_period;
      act_duty   <= sh_duty;
      act_mode   <= next_mode;
    end
  end
endmodule

// File: rtl/pwm_wavegen.sv
module pwm_wavegen
  import pwm_lock_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] act_period,
  input  logic [W-1:0] act_duty,
  input  wave_mode_t   act_mode,
  output logic         boundary,
  output logic         pwm_out
);
  logic [W-1:0] cnt;
  logic         per_zero;
  logic         level;

  assign per_zero = (act_period == '0);
  assign boundary = ~act_mode.run | per_zero | (cnt >= act_period - W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= boundary ? '0 : cnt + W'(1);
    end
  end

  always_comb begin
    if (act_mode.run && !per_zero)
      level = (cnt < act_duty) ? act_mode.act_hi : act_mode.idle_hi;
    else
      level = act_mode.idle_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b0;
    else     pwm_out <= level;
  end
endmodule

// File: rtl/pwm_lock_chan.sv
module pwm_lock_chan
  import pwm_lock_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PRESCALE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pwm_out
);
  logic              tick;
  logic              boundary;
  logic              commit;
  ctrl_view_t        sh_ctrl;
  logic [DATA_W-1:0] sh_period;
  logic [DATA_W-1:0] sh_duty;
  logic [DATA_W-1:0] act_period;
  logic [DATA_W-1:0] act_duty;
  wave_mode_t        act_mode;

  pwm_tick_gen #(.DIV(PRESCALE)) tick_i (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  pwm_shadow_regs #(.W(DATA_W)) regs_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .sh_ctrl  (sh_ctrl),
    .sh_period(sh_period),
    .sh_duty  (sh_duty)
  );

  pwm_commit #(.W(DATA_W)) commit_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .boundary  (boundary),
    .sh_ctrl   (sh_ctrl),
    .sh_period (sh_period),
    .sh_duty   (sh_duty),
    .commit    (commit),
    .act_period(act_period),
    .act_duty  (act_duty),
    .act_mode  (act_mode)
  );

  pwm_wavegen #(.W(DATA_W)) wave_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .act_period(act_period),
    .act_duty  (act_duty),
    .act_mode  (act_mode),
    .boundary  (boundary),
    .pwm_out   (pwm_out)
  );
endmodule

// File: rtl/pwm_lock_chan_chk.sv
module pwm_lock_chan_chk #(
  parameter int W   = 32,
  parameter int DIV = 2
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         commit,
  input logic         lock,
  input logic [W-1:0] act_period,
  input logic [W-1:0] act_duty,
  input logic         act_run,
  input logic         act_hi,
  input logic         act_idle,
  input logic         pwm_out
);
  // R9: active configuration changes only in the cycle after a commit
  assert_commit_boundary_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (!$stable(act_period) || !$stable(act_duty) ||
                     !$stable(act_run) || !$stable(act_hi) || !$stable(act_idle)))
    |-> $past(commit));

  // R8: a set lock keeps the running period and duty frozen
  assert_lock_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lock)) |-> ($stable(act_period) && $stable(act_duty)));

  // R3: not running means the idle level on the output
  assert_idle_level_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!act_run)) |-> (pwm_out == $past(act_idle)));

  // R7: zero period means the idle level
  assert_zero_period_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(act_period == '0)) |-> (pwm_out == $past(act_idle)));

  // R6: duty at or above a nonzero period keeps the active level
  assert_full_duty_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(act_run && act_period != '0 && act_duty >= act_period))
    |-> (pwm_out == $past(act_hi)));

  generate
    if (DIV > 1) begin : g_tick_chk
      // R4: ticks are spaced by the prescaler, never back to back
      assert_tick_gap_R4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

bind pwm_lock_chan pwm_lock_chan_chk #(.W(DATA_W), .DIV(PRESCALE)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .commit    (commit),
  .lock      (sh_ctrl.lock),
  .act_period(act_period),
  .act_duty  (act_duty),
  .act_run   (act_mode.run),
  .act_hi    (act_mode.act_hi),
  .act_idle  (act_mode.idle_hi),
  .pwm_out   (pwm_out)
);

// File: tb/pwm_lock_chan_tb_top.sv
`timescale 1ns/1ps
module pwm_lock_chan_tb_top;
  localparam int DW = 32;
  localparam int PS = 2;

  typedef struct packed {
    logic [15:0] per;
    logic [15:0] duty;
    logic        inv;
    logic [15:0] exp_act;
    logic [15:0] exp_idle;
  } vec_t;

  // active/idle lengths in clocks = PS * ticks
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{16'd4,  16'd1, 1'b0, 16'd2,  16'd6},
    '{16'd4,  16'd2, 1'b0, 16'd4,  16'd4},
    '{16'd8,  16'd3, 1'b1, 16'd6,  16'd10},
    '{16'd10, 16'd9, 1'b0, 16'd18, 16'd2},
    '{16'd6,  16'd5, 1'b1, 16'd10, 16'd2},
    '{16'd3,  16'd1, 1'b0, 16'd2,  16'd4}
  };

  localparam logic [DW-1:0] C_NORM = 32'h0B;
  localparam logic [DW-1:0] C_INV  = 32'h13;
  localparam logic [DW-1:0] C_LOCK = 32'h40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          pwm_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  pwm_lock_chan #(.DATA_W(DW), .PRESCALE(PS)) dut_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .pwm_out(pwm_out)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic cfg(input int per, input int duty, input logic [DW-1:0] ctrl);
    wr(2'd0, ctrl | C_LOCK);
    wr(2'd1, DW'(per));
    wr(2'd2, DW'(duty));
    wr(2'd0, ctrl);
    repeat (60) @(negedge clk);
  endtask

  // lengths in clocks of one active phase then the following idle phase
  task automatic measure(input logic lvl, output int a_len, output int i_len);
    int guard = 0;
    a_len = -1; i_len = -1;
    while (pwm_out == lvl && guard < 5000) begin @(negedge clk); guard++; end
    while (pwm_out != lvl && guard < 5000) begin @(negedge clk); guard++; end
    if (guard >= 5000) return;
    a_len = 0;
    while (pwm_out == lvl && a_len < 5000) begin @(negedge clk); a_len++; end
    i_len = 0;
    while (pwm_out != lvl && i_len < 5000) begin @(negedge clk); i_len++; end
  endtask

  task automatic check_const(input string tag, input logic lvl);
    int miss = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (pwm_out !== lvl) miss++;
    end
    check(tag, miss, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] r;
    int a, i;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 pwm_out after reset", pwm_out, 0);
    rd(2'd0, r); check("R1 ctrl after reset", r, 0);
    rd(2'd1, r); check("R1 period after reset", r, 0);
    rd(2'd2, r); check("R1 duty after reset", r, 0);

    // R2: read-back and unused select
    wr(2'd1, 32'h1234_5678); rd(2'd1, r); check("R2 period readback", r, 32'h1234_5678);
    wr(2'd2, 32'hCAFE_0001); rd(2'd2, r); check("R2 duty readback", r, 32'hCAFE_0001);
    wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, r); check("R2 select 3 reads zero", r, 0);
    rd(2'd1, r); check("R2 select 3 write ignored", r, 32'h1234_5678);

    // R4 / R5: table of waveforms
    for (int v = 0; v < NV; v++) begin
      cfg(int'(VECS[v].per), int'(VECS[v].duty), VECS[v].inv ? C_INV : C_NORM);
      measure(~VECS[v].inv, a, i);
      measure(~VECS[v].inv, a, i);
      check($sformatf("R4 R5 vec%0d active", v), a, VECS[v].exp_act);
      check($sformatf("R4 R5 vec%0d idle", v), i, VECS[v].exp_idle);
    end

    // R3: run qualification
    cfg(4, 2, 32'h0A);          check_const("R3 enable clear", 1'b0);
    cfg(4, 2, 32'h09);          check_const("R3 continuous clear", 1'b0);
    cfg(4, 2, C_NORM | 32'h20); check_const("R3 alignment set", 1'b0);
    cfg(4, 2, C_NORM | 32'h100); check_const("R3 low power set", 1'b0);
    cfg(4, 2, 32'h12);          check_const("R3 R5 idle high when stopped", 1'b1);

    // R6: duty at or above period
    cfg(4, 5, C_NORM); check_const("R6 duty above period", 1'b1);
    cfg(4, 4, C_INV);  check_const("R6 duty equal period inverted", 1'b0);

    // R7: zero period
    cfg(0, 3, C_NORM); check_const("R7 zero period normal", 1'b0);
    cfg(0, 3, C_INV);  check_const("R7 zero period inverted", 1'b1);

    // R8: lock freezes running waveform
    cfg(4, 2, C_NORM);
    wr(2'd0, C_NORM | C_LOCK);
    wr(2'd1, 32'd10);
    wr(2'd2, 32'd5);
    repeat (100) @(negedge clk);
    measure(1'b1, a, i);
    check("R8 locked active", a, 4);
    check("R8 locked idle", i, 4);
    rd(2'd1, r); check("R8 shadow period visible", r, 10);
    wr(2'd0, C_NORM);
    repeat (60) @(negedge clk);
    measure(1'b1, a, i);
    measure(1'b1, a, i);
    check("R8 unlocked active", a, 10);
    check("R8 unlocked idle", i, 10);

    // R9: mid-period write waits for the boundary
    while (pwm_out != 1'b0) @(negedge clk);
    while (pwm_out != 1'b1) @(negedge clk);
    wr(2'd2, 32'd1);
    repeat (5) @(negedge clk);
    check("R9 old duty kept mid period", pwm_out, 1);
    measure(1'b1, a, i);
    measure(1'b1, a, i);
    check("R9 new duty active", a, 2);
    check("R9 new duty idle", i, 18);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule